// File: doc/BRIEF.md
# Split/Cascade Up-Down Counter with Direction-Change Flag

This block holds one counter body that software can run as two independent 8-bit up/down channels or join into a single 16-bit channel. The choice is made by a mode bit in a 16-bit control register, which is reached through a byte-wide register port with read and write strobes. Each channel takes per-cycle up and down count pulses sampled on the system clock. Each channel raises a one-cycle pulse when it wraps past its top or bottom value.

A sticky status flag records that the count direction of channel 0 has turned, either from up to down or from down to up. The direction starts as down after reset, so the first up count after reset already sets the flag. Software clears the flag by writing 0 to its bit. Writing 1 to that bit does nothing. A read issued as part of a read-modify-write shows the flag as 1, so the write-back that follows cannot clear it by accident. An interrupt request follows the flag when its enable bit is set.

The register port and the count inputs are plain per-cycle strobes. They have no handshake, and the block never applies back-pressure.

Top module: `updn_split_counter`

## Requirements
- R1: After reset both counter bytes are 0x00, both wrap pulses are low, the flag and the interrupt are low, the recorded direction is down, the upper control byte (reg_addr=0) reads 0x00 and the lower control byte (reg_addr=1) reads 0x08.
- R2: Bit 7 of the upper control byte selects the mode: 0 gives two independent channels and 1 gives one cascaded channel. In cascaded mode, the carry or borrow out of count_lo steps count_hi at the same clock edge, and cnt_up[1]/cnt_dn[1] are ignored.
- R3: A net up count on channel 0 while the recorded direction is down, or a net down count while it is up, sets the flag (bit 6 of the upper byte) at that edge. The first up count after reset therefore sets it. A down count that follows reset does not set it.
- R4: A write to the upper byte with bit 6 = 0 clears the flag. A write with bit 6 = 1 leaves the flag unchanged.
- R5: If a direction turn and a clearing write happen in the same cycle, the flag ends up as 1.
- R6: A read of the upper byte with reg_rmw=1 returns bit 6 as 1. A plain read returns the true flag. Read data is combinational and is valid in the same cycle as reg_rd. It is 0x00 when reg_rd is low.
- R7: Each channel wraps modulo 2^8. In cascaded mode the whole counter wraps modulo 2^16. A wrap raises wrap_up[i] or wrap_dn[i] for one cycle, together with the wrapped value. In cascaded mode only index 1 reports the wrap, and index 0 stays low.
- R8: When up and down pulses arrive together on a channel, that channel holds its count. On channel 0 the recorded direction is also kept and the flag is not set.
- R9: irq is high exactly while the flag is 1 and bit 5 of the upper byte (interrupt enable) is 1.
- R10: Bits 4:0 of the upper byte and all of the lower byte are plain read/write storage and read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Marks a read that belongs to a read-modify-write |
| reg_addr | input | 1 | Byte select: 0 = upper control byte, 1 = lower control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| cnt_up | input | 2 | Up count pulse per channel |
| cnt_dn | input | 2 | Down count pulse per channel |
| count_lo | output | 8 | Channel 0 value, or the low half in cascaded mode |
| count_hi | output | 8 | Channel 1 value, or the high half in cascaded mode |
| wrap_up | output | 2 | One-cycle pulse on an upward wrap, per channel |
| wrap_dn | output | 2 | One-cycle pulse on a downward wrap, per channel |
| dir_flag | output | 1 | Sticky direction-change flag |
| irq | output | 1 | Interrupt request |

## Verification
Count pulses, control writes, the flag and the wrap pulses all take effect at the first rising edge after the stimulus is presented. Their results are therefore due one cycle later. irq needs no extra cycle, because it follows the flag combinationally. Read data is due in the same cycle as the read strobe. The driver presents every stimulus at a falling edge, checks any read 1 ns later, and pushes the expected post-edge state into a queue. The monitor pops and compares that state 1 ns after the following rising edge, so each comparison falls in the cycle its result is due.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned WIDE_POS = 7;
  localparam int unsigned FLAG_POS = 6;
  localparam int unsigned IE_POS   = 5;
  localparam int unsigned SPARE_W  = 5;
  localparam logic [REG_W-1:0] CTL_LO_RST = 8'h08;
endpackage

// File: rtl/updn_channel.sv
module updn_channel #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         carry,
  output logic         borrow
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign carry  = inc && (count == TOP);
  assign borrow = dec && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
    else if (dec) count <= count - 1'b1;
  end

  AST_CHAN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec)); // R8
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> count == '0); // R7
  AST_WRAP_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |=> count == TOP); // R7
endmodule

// File: rtl/updn_dirtrack.sv
module updn_dirtrack
  import updn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_up,
  input  logic step_dn,
  input  logic clr_req,
  output dir_e dir,
  output logic flag
);
  logic turn;
  assign turn = (step_up && dir == DIR_DOWN) || (step_dn && dir == DIR_UP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir  <= DIR_DOWN;
      flag <= 1'b0;
    end else begin
      if (step_up)      dir <= DIR_UP;
      else if (step_dn) dir <= DIR_DOWN;
      if (turn)         flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    turn |=> flag); // R5
  AST_FLAG_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_req)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn) |=> $stable(dir)); // R8
endmodule

// File: rtl/updn_ctrl_regs.sv
module updn_ctrl_regs
  import updn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             rmw,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             flag,
  output logic [REG_W-1:0] rdata,
  output logic             wide,
  output logic             ie,
  output logic             clr_req
);
  logic [SPARE_W-1:0] spare_q;
  logic [REG_W-1:0]   lo_q;
  logic [REG_W-1:0]   hi_view;

  assign clr_req = wr && !addr && !wdata[FLAG_POS];
  assign hi_view = {wide, (rmw ? 1'b1 : flag), ie, spare_q};
  assign rdata   = !rd ? '0 : (addr ? lo_q : hi_view);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide    <= 1'b0;
      ie      <= 1'b0;
      spare_q <= '0;
      lo_q    <= CTL_LO_RST;
    end else if (wr) begin
      if (addr) begin
        lo_q <= wdata;
      end else begin
        wide    <= wdata[WIDE_POS];
        ie      <= wdata[IE_POS];
        spare_q <= wdata[SPARE_W-1:0];
      end
    end
  end

  AST_RMW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rmw && !addr) |-> rdata[FLAG_POS]); // R6
  AST_LO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr) |=> lo_q == $past(wdata)); // R10
endmodule

// File: rtl/updn_split_counter.sv
module updn_split_counter
  import updn_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic            reg_rmw,
  input  logic            reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [1:0]      cnt_up,
  input  logic [1:0]      cnt_dn,
  output logic [CH_W-1:0] count_lo,
  output logic [CH_W-1:0] count_hi,
  output logic [1:0]      wrap_up,
  output logic [1:0]      wrap_dn,
  output logic            dir_flag,
  output logic            irq
);
  localparam int unsigned NCH = 2;

  logic [NCH-1:0] net_up, net_dn;
  logic [NCH-1:0] ch_inc, ch_dec, ch_carry, ch_borrow;
  logic [CH_W-1:0] ch_count [NCH];
  logic wide, ie, clr_req;
  dir_e dir;

  for (genvar g = 0; g < NCH; g++) begin : g_net
    assign net_up[g] = cnt_up[g] && !cnt_dn[g];
    assign net_dn[g] = cnt_dn[g] && !cnt_up[g];
  end

  assign ch_inc[0] = net_up[0];
  assign ch_dec[0] = net_dn[0];
  assign ch_inc[1] = wide ? ch_carry[0]  : net_up[1];
  assign ch_dec[1] = wide ? ch_borrow[0] : net_dn[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    updn_channel #(.W(CH_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (ch_inc[g]),
      .dec    (ch_dec[g]),
      .count  (ch_count[g]),
      .carry  (ch_carry[g]),
      .borrow (ch_borrow[g])
    );
  end

  assign count_lo = ch_count[0];
  assign count_hi = ch_count[1];

  updn_dirtrack u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (net_up[0]),
    .step_dn (net_dn[0]),
    .clr_req (clr_req),
    .dir     (dir),
    .flag    (dir_flag)
  );

  updn_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .rmw     (reg_rmw),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .flag    (dir_flag),
    .rdata   (reg_rdata),
    .wide    (wide),
    .ie      (ie),
    .clr_req (clr_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_up <= '0;
      wrap_dn <= '0;
    end else begin
      wrap_up <= {ch_carry[1],  !wide && ch_carry[0]};
      wrap_dn <= {ch_borrow[1], !wide && ch_borrow[0]};
    end
  end

  assign irq = dir_flag && ie;

  AST_CASCADE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && ch_carry[0]) |=> count_hi == CH_W'($past(count_hi) + 1'b1)); // R2
  AST_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !ch_carry[0] && !ch_borrow[0]) |=> $stable(count_hi)); // R2
  AST_WIDE_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && !(reg_wr && !reg_addr)) |=> (!wrap_up[0] && !wrap_dn[0])); // R7
  AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up[0] && cnt_dn[0]) |=> ($stable(count_lo) && $stable(dir))); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> dir_flag); // R9
endmodule

// File: tb/updn_split_counter_tb.sv
`timescale 1ns/1ps
module updn_split_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 0, reg_rd = 0, reg_rmw = 0, reg_addr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_up = '0, cnt_dn = '0;
  logic [7:0] count_lo, count_hi;
  logic [1:0] wrap_up, wrap_dn;
  logic       dir_flag, irq;

  always #2.5 clk = ~clk;

  updn_split_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rmw(reg_rmw), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .count_lo(count_lo), .count_hi(count_hi), .wrap_up(wrap_up),
    .wrap_dn(wrap_dn), .dir_flag(dir_flag), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] lo, hi;
    logic [1:0] wu, wd;
    logic       fl, iq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0, miscompares = 0;
  bit    done = 0;

  // reference state
  logic [7:0] m_lo = 0, m_hi = 0, m_ctll = 8'h08;
  logic [4:0] m_spare = 0;
  logic       m_dir = 0, m_flag = 0, m_wide = 0, m_ie = 0;

  task automatic step(input logic [1:0] up, input logic [1:0] dn, input logic wr,
                      input logic rd, input logic rmw, input logic addr,
                      input logic [7:0] wd, input string tag);
    logic [7:0] rexp;
    logic lu, ld, hu, hd, lc, lb, hc, hb, turn, clr;
    exp_t e;
    @(negedge clk);
    cnt_up = up; cnt_dn = dn; reg_wr = wr; reg_rd = rd; reg_rmw = rmw;
    reg_addr = addr; reg_wdata = wd;
    #1;
    if (rd) begin
      rexp = addr ? m_ctll : {m_wide, (rmw ? 1'b1 : m_flag), m_ie, m_spare};
      vectors++;
      if (reg_rdata !== rexp) begin
        miscompares++;
        $display("FAIL %s read addr=%0d: got %h expected %h", tag, addr, reg_rdata, rexp);
      end
    end
    lu = up[0] && !dn[0]; ld = dn[0] && !up[0];
    lc = lu && m_lo == 8'hFF; lb = ld && m_lo == 8'h00;
    hu = m_wide ? lc : (up[1] && !dn[1]);
    hd = m_wide ? lb : (dn[1] && !up[1]);
    hc = hu && m_hi == 8'hFF; hb = hd && m_hi == 8'h00;
    turn = (lu && !m_dir) || (ld && m_dir);
    clr = wr && !addr && !wd[6];
    m_flag = turn ? 1'b1 : (clr ? 1'b0 : m_flag);
    if (lu) m_dir = 1'b1; else if (ld) m_dir = 1'b0;
    e.wu = {hc, !m_wide && lc};
    e.wd = {hb, !m_wide && lb};
    if (lu) m_lo = m_lo + 8'd1; else if (ld) m_lo = m_lo - 8'd1;
    if (hu) m_hi = m_hi + 8'd1; else if (hd) m_hi = m_hi - 8'd1;
    if (wr) begin
      if (addr) m_ctll = wd;
      else begin m_wide = wd[7]; m_ie = wd[5]; m_spare = wd[4:0]; end
    end
    e.lo = m_lo; e.hi = m_hi; e.fl = m_flag; e.iq = m_flag && m_ie;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic cnt(input logic [1:0] up, input logic [1:0] dn, input string tag);
    step(up, dn, 0, 0, 0, 0, 8'h00, tag);
  endtask
  task automatic wreg(input logic addr, input logic [7:0] d, input string tag);
    step(2'b00, 2'b00, 1, 0, 0, addr, d, tag);
  endtask
  task automatic rreg(input logic addr, input logic rmw, input string tag);
    step(2'b00, 2'b00, 0, 1, rmw, addr, 8'h00, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if ({count_lo, count_hi, wrap_up, wrap_dn, dir_flag, irq} !== e) begin
          miscompares++;
          $display("FAIL %s: got lo=%h hi=%h wu=%b wd=%b fl=%b irq=%b expected lo=%h hi=%h wu=%b wd=%b fl=%b irq=%b",
                   t, count_lo, count_hi, wrap_up, wrap_dn, dir_flag, irq,
                   e.lo, e.hi, e.wu, e.wd, e.fl, e.iq);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    vectors++;
    if ({count_lo, count_hi, wrap_up, wrap_dn, dir_flag, irq} !== '0) begin
      miscompares++;
      $display("FAIL R1 reset outputs: got %h expected 0",
               {count_lo, count_hi, wrap_up, wrap_dn, dir_flag, irq});
    end
    rreg(0, 0, "R1 upper byte");
    rreg(1, 0, "R1 lower byte");
    cnt(2'b00, 2'b01, "R3 R7 first down, wrap");
    cnt(2'b01, 2'b00, "R3 first up sets flag");
    cnt(2'b10, 2'b00, "R2 split ch1 up");
    cnt(2'b00, 2'b10, "R2 split ch1 down");
    cnt(2'b00, 2'b10, "R7 ch1 wrap down");
    wreg(0, 8'h60, "R4 R9 write one keeps flag");
    rreg(0, 1, "R6 rmw read");
    wreg(0, 8'h20, "R4 R9 clear flag");
    rreg(0, 0, "R6 plain read");
    rreg(0, 1, "R6 rmw read forced");
    cnt(2'b11, 2'b11, "R8 cancel both");
    cnt(2'b01, 2'b00, "R8 same dir no flag");
    cnt(2'b00, 2'b01, "R3 up to down");
    wreg(0, 8'h20, "R4 clear");
    cnt(2'b01, 2'b01, "R8 cancel keeps dir");
    cnt(2'b01, 2'b00, "R3 down to up");
    wreg(0, 8'h20, "R4 clear");
    step(2'b00, 2'b01, 1, 0, 0, 0, 8'h20, "R5 set wins");
    wreg(1, 8'hA5, "R10 lower write");
    rreg(1, 0, "R10 lower read");
    wreg(0, 8'h3F, "R10 upper spare");
    rreg(0, 0, "R10 upper read");
    wreg(0, 8'h00, "R9 disable irq");
    wreg(0, 8'h80, "R2 enter wide");
    for (int i = 0; i < 256; i++) cnt(2'b01, 2'b00, "R2 R7 wide count up");
    cnt(2'b10, 2'b00, "R2 hi inputs ignored");
    cnt(2'b00, 2'b01, "R7 wide wrap down");
    cnt(2'b01, 2'b00, "R7 wide wrap up");
    cnt(2'b10, 2'b01, "R2 borrow cascades");
    wreg(0, 8'h00, "R2 back to split");
    cnt(2'b00, 2'b01, "R2 split no cascade");
    cnt(2'b00, 2'b00, "idle");
    cnt(2'b00, 2'b00, "idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule